// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation buffer that turns virtual page numbers into physical frame numbers for the address space that is active. Each slot holds a page number, a frame number, the address-space number that was current when the slot was filled, a global flag and a cacheable flag. A lookup is resolved within the cycle and returns hit, miss, frame and the cacheable attribute. The cacheable bit lets ranges such as memory-mapped I/O be marked as not to be cached.

An external page-walk agent loads the buffer through a fill port. It reads the page-table base from this block to locate the tables of the running process. The operating system writes the current address-space number and the page-table base through a small register port. It keeps the buffer coherent with three invalidate commands: everything, every non-global slot (for a context switch when tags are not used), or every non-global slot of one address-space number (when a tag is recycled). Because entries carry tags, translations of several processes coexist, and a switch only needs a new address-space number.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, `cur_asid` is 0 and `pt_base` is 0, so every lookup misses.
- R2: A non-global slot hits only when its page number equals `lk_vpn` and its stored tag equals `cur_asid`. A hit drives `lk_hit`=1 and `lk_miss`=0, with the slot's frame on `lk_pfn` and its cacheable bit on `lk_cache`. The tag stored by a fill is the `cur_asid` value in that cycle.
- R3: A slot filled with `fill_glob`=1 hits on the page number alone, for any value of `cur_asid`.
- R4: Non-global slots of different address-space numbers may hold the same page number with different frames and cacheable bits. Each lookup returns the mapping of the current address space.
- R5: `inv_asid_en` with `inv_asid` clears the non-global slots whose tag equals `inv_asid`. Global slots and slots of other tags stay valid.
- R6: `inv_nonglob` clears every non-global slot and leaves global slots valid.
- R7: `inv_all` clears every slot, global ones included.
- R8: On a miss, `lk_miss`=1, `lk_hit`=0, `lk_pfn`=0 and `lk_cache`=0.
- R9: `reg_we` with `reg_sel`=0 loads `cur_asid` from the low bits of `reg_wdata`. With `reg_sel`=1 it loads `pt_base` from `reg_wdata`. Both take effect from the next cycle.
- R10: A fill whose page number would already hit in the current address space overwrites that slot and does not advance the replacement pointer.
- R11: Other fills go to the slot named by a round-robin pointer, which then advances by one. After 16 fills of new pages, the 17th evicts the first of them.
- R12: When any invalidate command is asserted in the same cycle as `fill_en`, the fill is dropped and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation found |
| lk_pfn | output | PFN_W | Frame number, 0 on a miss |
| lk_cache | output | 1 | Cacheable attribute, 0 on a miss |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page number to fill |
| fill_pfn | input | PFN_W | Frame number to fill |
| fill_glob | input | 1 | Fill as a global translation |
| fill_cache | input | 1 | Cacheable attribute to fill |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects address-space number, 1 selects table base |
| reg_wdata | input | PTB_W | Register write data |
| cur_asid | output | ASID_W | Current address-space number |
| pt_base | output | PTB_W | Page-table base for the walk agent |
| inv_all | input | 1 | Invalidate every slot |
| inv_nonglob | input | 1 | Invalidate all non-global slots |
| inv_asid_en | input | 1 | Invalidate non-global slots of one tag |
| inv_asid | input | ASID_W | Tag for the selective invalidate |

## Verification
A fill and an invalidate can land in the same cycle. The bench provokes this by asserting `fill_en` together with an invalidate for an unrelated tag, and again together with `inv_all`. It then judges the result at the lookup port: the filled page must miss. A following fill must land in the slot the round-robin pointer held before the collision, which shows that the pointer did not move. A fill that matches an existing translation is also followed by a fill of a new page, and the bench checks which older page that second fill evicts.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PTB_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_cache,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_glob,
  input  logic              fill_cache,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [PTB_W-1:0]  reg_wdata,
  output logic [ASID_W-1:0] cur_asid,
  output logic [PTB_W-1:0]  pt_base,
  input  logic              inv_all,
  input  logic              inv_nonglob,
  input  logic              inv_asid_en,
  input  logic [ASID_W-1:0] inv_asid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, glb, cch;
  logic [VPN_W-1:0]   tv [ENTRIES];
  logic [PFN_W-1:0]   pf [ENTRIES];
  logic [ASID_W-1:0]  tg [ENTRIES];
  logic [IDX_W-1:0]   ptr, widx;
  logic [ENTRIES-1:0] lk_m, fl_m;
  logic [PFN_W-1:0]   pfn_or;
  logic               cch_or, fl_hit;

  wire inv_any = inv_all | inv_nonglob | inv_asid_en;
  wire fill_ok = fill_en & ~inv_any;

  always_comb begin
    pfn_or = '0;
    cch_or = 1'b0;
    fl_hit = 1'b0;
    widx   = ptr;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_m[i] = vld[i] && tv[i] == lk_vpn   && (glb[i] || tg[i] == cur_asid);
      fl_m[i] = vld[i] && tv[i] == fill_vpn && (glb[i] || tg[i] == cur_asid);
      pfn_or  = pfn_or | ({PFN_W{lk_m[i]}} & pf[i]);
      cch_or  = cch_or | (lk_m[i] & cch[i]);
      if (fl_m[i] && !fl_hit) begin
        fl_hit = 1'b1;
        widx   = IDX_W'(i);
      end
    end
  end

  assign lk_hit   = |lk_m;
  assign lk_miss  = ~lk_hit;
  assign lk_pfn   = pfn_or;
  assign lk_cache = cch_or;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      ptr      <= '0;
      cur_asid <= '0;
      pt_base  <= '0;
    end else begin
      if (reg_we && !reg_sel) cur_asid <= reg_wdata[ASID_W-1:0];
      if (reg_we &&  reg_sel) pt_base  <= reg_wdata;
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_all)
          vld[i] <= 1'b0;
        else if (inv_nonglob && !glb[i])
          vld[i] <= 1'b0;
        else if (inv_asid_en && !glb[i] && tg[i] == inv_asid)
          vld[i] <= 1'b0;
      end
      if (fill_ok) begin
        vld[widx] <= 1'b1;
        if (!fl_hit)
          ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      tv[widx]  <= fill_vpn;
      pf[widx]  <= fill_pfn;
      tg[widx]  <= cur_asid;
      glb[widx] <= fill_glob;
      cch[widx] <= fill_cache;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PTB_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [PFN_W-1:0]  lk_pfn,
  input logic              lk_cache,
  input logic              fill_en,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic [PFN_W-1:0]  fill_pfn,
  input logic              fill_cache,
  input logic              reg_we,
  input logic              reg_sel,
  input logic [PTB_W-1:0]  reg_wdata,
  input logic [ASID_W-1:0] cur_asid,
  input logic [PTB_W-1:0]  pt_base,
  input logic              inv_all,
  input logic              inv_nonglob,
  input logic              inv_asid_en
);
  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (!lk_hit && lk_pfn == '0 && !lk_cache));

  // R7
  inv_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);

  // R9
  asid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> cur_asid == $past(reg_wdata[ASID_W-1:0]));

  // R9
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel) |=> pt_base == $past(reg_wdata));

  // R2
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_all && !inv_nonglob && !inv_asid_en && !reg_we) |=>
      (lk_vpn != $past(fill_vpn)) ||
      (lk_hit && lk_pfn == $past(fill_pfn) && lk_cache == $past(fill_cache)));
endmodule

bind asid_tlb asid_tlb_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .PTB_W(PTB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_pfn(lk_pfn), .lk_cache(lk_cache), .fill_en(fill_en), .fill_vpn(fill_vpn),
  .fill_pfn(fill_pfn), .fill_cache(fill_cache), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .cur_asid(cur_asid), .pt_base(pt_base), .inv_all(inv_all),
  .inv_nonglob(inv_nonglob), .inv_asid_en(inv_asid_en)
);

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_pfn = '0;
  logic        lk_hit, lk_miss, lk_cache;
  logic [19:0] lk_pfn;
  logic        fill_en = 0, fill_glob = 0, fill_cache = 0;
  logic        reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0, pt_base;
  logic [7:0]  cur_asid, inv_asid = '0;
  logic        inv_all = 0, inv_nonglob = 0, inv_asid_en = 0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  asid_tlb dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %0h exp %0h", r, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    fill_en = 0; reg_we = 0; inv_all = 0; inv_nonglob = 0; inv_asid_en = 0;
  endtask

  task automatic look(input string r, input logic [19:0] v, input bit eh,
                      input logic [19:0] ep, input bit ec);
    lk_vpn = v; #0.2;
    chk({r, " hit"}, 32'(lk_hit), 32'(eh));
    chk({r, " miss"}, 32'(lk_miss), 32'(!eh));
    chk({r, " pfn"}, 32'(lk_pfn), eh ? 32'(ep) : 32'h0);
    chk({r, " cache"}, 32'(lk_cache), eh ? 32'(ec) : 32'h0);
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d; step();
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input bit g, input bit c);
    fill_en = 1; fill_vpn = v; fill_pfn = p; fill_glob = g; fill_cache = c; step();
  endtask

  function automatic logic [19:0] pmap(input int v);
    return 20'(v * 3 + 7);
  endfunction

  initial begin
    #200000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 asid", 32'(cur_asid), 0);
    chk("R1 base", pt_base, 0);
    for (int v = 0; v < 4; v++) look("R1 R8 empty", 20'(v), 0, 0, 0);

    // R9 register sweep
    for (int k = 1; k < 6; k++) begin
      wr(0, 32'h100 * k + k);
      chk("R9 asid", 32'(cur_asid), 32'(8'(k + 32'h100 * k)));
      wr(1, 32'h1000_0000 + 32'(k * 4096));
      chk("R9 base", pt_base, 32'h1000_0000 + 32'(k * 4096));
    end

    // R2 / R4
    wr(0, 1);
    fill(20'h10, 20'h100, 0, 1);
    look("R2 own asid", 20'h10, 1, 20'h100, 1);
    wr(0, 2);
    look("R2 R8 other asid", 20'h10, 0, 0, 0);
    fill(20'h10, 20'h200, 0, 0);
    look("R4 asid2", 20'h10, 1, 20'h200, 0);
    wr(0, 1);
    look("R4 asid1", 20'h10, 1, 20'h100, 1);

    // R3 global
    fill(20'h80, 20'h800, 1, 0);
    for (int a = 0; a < 8; a++) begin
      wr(0, 32'(a * 37));
      look("R3 global", 20'h80, 1, 20'h800, 0);
    end

    // R5 flush by tag
    inv_asid_en = 1; inv_asid = 1; step();
    wr(0, 1);
    look("R5 tag1 gone", 20'h10, 0, 0, 0);
    look("R5 global kept", 20'h80, 1, 20'h800, 0);
    wr(0, 2);
    look("R5 tag2 kept", 20'h10, 1, 20'h200, 0);

    // R6 non-global flush
    inv_nonglob = 1; step();
    look("R6 nonglobal gone", 20'h10, 0, 0, 0);
    look("R6 global kept", 20'h80, 1, 20'h800, 0);

    // R7 invalidate all
    inv_all = 1; step();
    look("R7 global gone", 20'h80, 0, 0, 0);

    // R11 round robin sweep
    wr(0, 3);
    for (int v = 0; v < 16; v++) fill(20'(v), pmap(v), 0, v[0]);
    for (int v = 0; v < 16; v++) look("R11 full", 20'(v), 1, pmap(v), v[0]);
    fill(20'h40, 20'h444, 0, 1);
    look("R11 oldest evicted", 20'h0, 0, 0, 0);
    for (int v = 1; v < 16; v++) look("R11 others kept", 20'(v), 1, pmap(v), v[0]);
    look("R11 new", 20'h40, 1, 20'h444, 1);

    // R10 overwrite does not allocate
    fill(20'h5, 20'h555, 0, 0);
    look("R10 overwritten", 20'h5, 1, 20'h555, 0);
    fill(20'h41, 20'h411, 0, 0);
    look("R10 next victim", 20'h1, 0, 0, 0);
    look("R10 pointer held", 20'h2, 1, pmap(2), 0);

    // R12 invalidate beats fill
    inv_asid_en = 1; inv_asid = 8'h99;
    fill(20'h50, 20'h505, 0, 1);
    look("R12 fill dropped", 20'h50, 0, 0, 0);
    look("R12 tag flush spared", 20'h3, 1, pmap(3), 1);
    fill(20'h42, 20'h422, 0, 0);
    look("R12 pointer unmoved", 20'h2, 0, 0, 0);
    look("R12 slot after", 20'h3, 1, pmap(3), 1);
    inv_all = 1;
    fill(20'h51, 20'h515, 1, 1);
    look("R12 inv_all fill dropped", 20'h51, 0, 0, 0);
    look("R7 R12 all gone", 20'h42, 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule